// File: doc/BRIEF.md
# Descriptor Table Driven Data Mover

This block moves data between an on-chip memory and external memory under the control of a 32-entry descriptor table. Software fills the table through a small register port. Each descriptor holds an on-chip offset, a byte count, an external address and a few control bits. Software then writes one control word. That word names an inclusive range of descriptors and sets the direction, a bridge tag and the burst size. The same write starts the walk at once.

The walk handles the selected descriptors one at a time, from the lowest index to the highest. It splits each descriptor into bursts on a simple valid/ready request port. Both addresses advance by the length of every burst that is accepted. When the last descriptor is finished, a status bit is set. The interrupt line is that bit unless the mask register blocks it. Software clears the bit by writing to a clear register.

Top module: `desc_mover`

## Requirements
- R1: Descriptor n occupies the register window starting at 0x1010 + n*24. The on-chip offset is at +0, the byte count at +4, the external address at +8 and the control bits at +0x10. Every field reads back what was last written to it.
- R2: A write to 0x1000 while idle starts a walk and is stored for read-back. Its fields are: bit 0 direction, bit 1 burst size (0 gives 128 bytes, 1 gives 256 bytes), bits 7:4 bridge tag, bits 20:16 first index and bits 28:24 last index.
- R3: Descriptors are handled in ascending order from the first index to the last. A descriptor is skipped and issues no request when its enable bit (control bit 0) is clear or its byte count is zero.
- R4: A descriptor's first burst starts at its on-chip offset and at its external address. Each burst length is the smaller of the bytes remaining and the burst size. Each accepted burst advances both addresses by its length.
- R5: Every request carries the walk's direction and bridge tag, and the descriptor's read-only flag (control bit 2). A request held with ready low keeps all of its fields stable.
- R6: Bit 0 of the general status register at 0x14 reads 1 while a walk is in progress and 0 once it has ended.
- R7: A write to 0x1000 during a walk is ignored. The stored control word and the sequence of requests are unchanged.
- R8: Completion sets bit 0 of the interrupt status register at 0x10. It happens on the clock edge that accepts the final burst, or that skips the final descriptor, and on that same edge the busy bit drops.
- R9: Writing 1 to bit 0 of 0x8 clears the status bit, and writing 0 there has no effect. When a clear and a completion fall on the same edge, the bit ends up set.
- R10: Writing 1 to bit 0 of the mask register at 0xC blocks the interrupt line. The line is high exactly when the status bit is set and not masked.
- R11: A control word whose first index is greater than its last index issues no request and never sets busy. It sets the status bit on its write edge.
- R12: After reset the walk is idle, no request is pending, status, mask and interrupt are 0, and every descriptor's control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mreq_valid | output | 1 | Burst request valid |
| mreq_ready | input | 1 | Burst request accepted when high with valid |
| mreq_local | output | 32 | On-chip byte address of the burst |
| mreq_ext | output | 32 | External byte address of the burst |
| mreq_len | output | 9 | Burst length in bytes |
| mreq_dir | output | 1 | Transfer direction from the control word |
| mreq_bridge | output | 4 | Bridge tag from the control word |
| mreq_ro | output | 1 | Read-only flag of the current descriptor |
| irq | output | 1 | Completion interrupt |

## Verification
A stale index or a wrong remaining count shows up on the very next accepted burst. The request port then carries an address or length that differs from the bench's computed stream, or the number of bursts in a walk comes out wrong. A busy flag or completion bit that is out of step appears as a status read-back that disagrees within a cycle of the final burst. It also appears as an interrupt line that does not follow the mask. The bench sweeps every first/last pair over ten programmed descriptors. These include skipped, zero-length, read-only and multi-burst entries, and the request port is stalled by a pseudo-random ready pattern.

// File: rtl/desc_mover.sv
module desc_mover #(
  parameter int ENTRIES = 32,
  parameter int DW      = 32,
  parameter int AW      = 13,
  parameter int LENW    = 9,
  parameter int BRW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic [DW-1:0]   mreq_local,
  output logic [DW-1:0]   mreq_ext,
  output logic [LENW-1:0] mreq_len,
  output logic            mreq_dir,
  output logic [BRW-1:0]  mreq_bridge,
  output logic            mreq_ro,
  output logic            irq
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam logic [AW-1:0] A_CLR  = AW'(8);
  localparam logic [AW-1:0] A_MASK = AW'(12);
  localparam logic [AW-1:0] A_STAT = AW'(16);
  localparam logic [AW-1:0] A_GEN  = AW'(20);
  localparam logic [AW-1:0] A_CTRL = AW'(4096);
  localparam logic [AW-1:0] A_TBL  = AW'(4112);
  localparam logic [AW-1:0] STRIDE = AW'(24);
  localparam logic [AW-1:0] A_TEND = A_TBL + AW'(ENTRIES * 24);
  localparam logic [LENW-1:0] BLK_S = LENW'(128);
  localparam logic [LENW-1:0] BLK_L = LENW'(256);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_BURST} st_t;

  logic [DW-1:0] t_off  [ENTRIES];
  logic [DW-1:0] t_size [ENTRIES];
  logic [DW-1:0] t_addr [ENTRIES];
  logic [2:0]    t_ctl  [ENTRIES];

  st_t           state;
  logic [IDXW-1:0] cur, last_q;
  logic [DW-1:0] loc, ext, rem, ctrl_q;
  logic          ro_q, st_done, mask_q;

  logic          in_tbl;
  logic [AW-1:0] rel, ridx_w, rsub;
  logic [IDXW-1:0] ridx, w_first, w_last;
  logic          unused_hi;
  logic          start, empty, busy, ent_ok, last_burst, adv, fin, set_done, clr;
  logic [LENW-1:0] blk;

  assign in_tbl   = (reg_addr >= A_TBL) && (reg_addr < A_TEND);
  assign rel      = reg_addr - A_TBL;
  assign ridx_w   = rel / STRIDE;
  assign rsub     = rel % STRIDE;
  assign ridx     = ridx_w[IDXW-1:0];
  assign unused_hi = ^ridx_w[AW-1:IDXW];

  assign w_first  = reg_wdata[16 +: IDXW];
  assign w_last   = reg_wdata[24 +: IDXW];
  assign empty    = w_first > w_last;
  assign busy     = state != S_IDLE;
  assign start    = reg_wr && reg_addr == A_CTRL && !busy;
  assign clr      = reg_wr && reg_addr == A_CLR && reg_wdata[0];

  assign blk        = ctrl_q[1] ? BLK_L : BLK_S;
  assign last_burst = rem <= DW'(blk);
  assign ent_ok     = t_ctl[cur][0] && (t_size[cur] != '0);
  assign adv        = (state == S_SCAN && !ent_ok) ||
                      (state == S_BURST && mreq_ready && last_burst);
  assign fin        = adv && cur == last_q;
  assign set_done   = fin || (start && empty);

  assign mreq_valid  = state == S_BURST;
  assign mreq_len    = last_burst ? rem[LENW-1:0] : blk;
  assign mreq_local  = loc;
  assign mreq_ext    = ext;
  assign mreq_dir    = ctrl_q[0];
  assign mreq_bridge = ctrl_q[4 +: BRW];
  assign mreq_ro     = ro_q;
  assign irq         = st_done && !mask_q;

  always_ff @(posedge clk) begin
    if (reg_wr && in_tbl) begin
      case (rsub)
        AW'(0): t_off[ridx]  <= reg_wdata;
        AW'(4): t_size[ridx] <= reg_wdata;
        AW'(8): t_addr[ridx] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) t_ctl[i] <= '0;
    end else if (reg_wr && in_tbl && rsub == AW'(16)) begin
      t_ctl[ridx] <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      last_q <= '0;
      loc    <= '0;
      ext    <= '0;
      rem    <= '0;
      ctrl_q <= '0;
      ro_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ctrl_q <= reg_wdata;
          cur    <= w_first;
          last_q <= w_last;
          if (!empty) state <= S_SCAN;
        end
        S_SCAN: if (ent_ok) begin
          loc   <= t_off[cur];
          ext   <= t_addr[cur];
          rem   <= t_size[cur];
          ro_q  <= t_ctl[cur][2];
          state <= S_BURST;
        end
        S_BURST: if (mreq_ready) begin
          loc <= loc + DW'(mreq_len);
          ext <= ext + DW'(mreq_len);
          rem <= rem - DW'(mreq_len);
        end
        default: state <= S_IDLE;
      endcase
      if (adv) begin
        if (cur == last_q) state <= S_IDLE;
        else begin
          cur   <= cur + 1'b1;
          state <= S_SCAN;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (set_done)  st_done <= 1'b1;
      else if (clr)  st_done <= 1'b0;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_tbl) begin
      case (rsub)
        AW'(0):  reg_rdata = t_off[ridx];
        AW'(4):  reg_rdata = t_size[ridx];
        AW'(8):  reg_rdata = t_addr[ridx];
        AW'(16): reg_rdata = DW'(t_ctl[ridx]);
        default: reg_rdata = '0;
      endcase
    end else begin
      case (reg_addr)
        A_MASK:  reg_rdata = DW'(mask_q);
        A_STAT:  reg_rdata = DW'(st_done);
        A_GEN:   reg_rdata = DW'(busy);
        A_CTRL:  reg_rdata = ctrl_q;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/desc_mover_chk.sv
module desc_mover_chk #(
  parameter int DW   = 32,
  parameter int AW   = 13,
  parameter int LENW = 9,
  parameter int BRW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic            mreq_valid,
  input logic            mreq_ready,
  input logic [DW-1:0]   mreq_local,
  input logic [DW-1:0]   mreq_ext,
  input logic [LENW-1:0] mreq_len,
  input logic            mreq_dir,
  input logic [BRW-1:0]  mreq_bridge,
  input logic            mreq_ro,
  input logic            busy,
  input logic            done_q,
  input logic [DW-1:0]   ctrl_q
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_local) && $stable(mreq_ext) &&
      $stable(mreq_len) && $stable(mreq_dir) && $stable(mreq_bridge) && $stable(mreq_ro));

  assert_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (mreq_len != '0) && (mreq_len <= (ctrl_q[1] ? LENW'(256) : LENW'(128))));

  assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> busy);

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == AW'(4096) |=> $stable(ctrl_q));
endmodule

bind desc_mover desc_mover_chk #(.DW(DW), .AW(AW), .LENW(LENW), .BRW(BRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_local(mreq_local),
  .mreq_ext(mreq_ext), .mreq_len(mreq_len), .mreq_dir(mreq_dir),
  .mreq_bridge(mreq_bridge), .mreq_ro(mreq_ro), .busy(busy),
  .done_q(st_done), .ctrl_q(ctrl_q)
);

// File: tb/tb_desc_mover.sv
module tb_desc_mover;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [31:0] mreq_local, mreq_ext;
  logic [8:0]  mreq_len;
  logic        mreq_dir, mreq_ro, irq;
  logic [3:0]  mreq_bridge;

  desc_mover dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mreq_valid(mreq_valid),
    .mreq_ready(mreq_ready), .mreq_local(mreq_local), .mreq_ext(mreq_ext),
    .mreq_len(mreq_len), .mreq_dir(mreq_dir), .mreq_bridge(mreq_bridge),
    .mreq_ro(mreq_ro), .irq(irq)
  );

  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  int unsigned m_off[32], m_size[32], m_addr[32];
  bit [2:0] m_ctl[32];
  int unsigned e_loc[256], e_ext[256], e_len[256];
  bit e_ro[256];
  int e_n = 0, got_n = 0;
  bit e_dir = 0, mask_m = 0, ready_mode = 1;
  bit [3:0] e_br = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mreq_ready = ready_mode ? 1'b1 : (lfsr[0] | lfsr[3]);
    if (mreq_valid && mreq_ready) begin
      if (got_n < e_n) begin
        chk(mreq_local == e_loc[got_n], "R4 burst on-chip address", mreq_local, e_loc[got_n]);
        chk(mreq_ext == e_ext[got_n], "R4 burst external address", mreq_ext, e_ext[got_n]);
        chk(mreq_len == e_len[got_n], "R4 burst length", mreq_len, e_len[got_n]);
        chk({mreq_dir, mreq_bridge, mreq_ro} == {e_dir, e_br, e_ro[got_n]},
            "R5 request attributes", {mreq_dir, mreq_bridge, mreq_ro}, {e_dir, e_br, e_ro[got_n]});
      end else begin
        chk(1'b0, "R3 unexpected extra request", got_n, e_n);
      end
      got_n++;
    end
  end

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 13'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int unsigned v);
    @(negedge clk);
    reg_addr = 13'(a);
    #1 v = reg_rdata;
  endtask

  task automatic prog(input int i, input int unsigned off, input int unsigned sz,
                      input int unsigned ad, input bit [2:0] ct);
    int b;
    b = 'h1010 + i * 24;
    wr(b, off); wr(b + 4, sz); wr(b + 8, ad); wr(b + 16, ct);
    m_off[i] = off; m_size[i] = sz; m_addr[i] = ad; m_ctl[i] = ct;
  endtask

  task automatic build(input int f, input int l, input bit blk);
    int unsigned bs, r, o, a, ln;
    bs = blk ? 256 : 128;
    e_n = 0;
    for (int i = f; i <= l; i++) begin
      if (m_ctl[i][0] && m_size[i] != 0) begin
        r = m_size[i]; o = m_off[i]; a = m_addr[i];
        while (r > 0) begin
          ln = (r < bs) ? r : bs;
          e_loc[e_n] = o; e_ext[e_n] = a; e_len[e_n] = ln; e_ro[e_n] = m_ctl[i][2];
          e_n++; o += ln; a += ln; r -= ln;
        end
      end
    end
  endtask

  function automatic int unsigned cword(input int f, input int l, input bit blk,
                                        input bit dir, input bit [3:0] br);
    return (32'(l) << 24) | (32'(f) << 16) | (32'(br) << 4) | (32'(blk) << 1) | 32'(dir);
  endfunction

  task automatic wait_idle();
    int unsigned v;
    v = 1;
    for (int k = 0; k < 20000 && v != 0; k++) rd('h14, v);
    chk(v == 0, "R6 busy clears after walk", v, 0);
  endtask

  task automatic run(input int f, input int l, input bit blk, input bit dir,
                     input bit [3:0] br, input bit poke);
    int unsigned v, cw;
    build(f, l, blk);
    got_n = 0; e_dir = dir; e_br = br;
    cw = cword(f, l, blk, dir, br);
    wr('h1000, cw);
    if (e_n > 0) begin
      rd('h14, v);
      chk(v == 1, "R6 busy during walk", v, 1);
    end
    if (poke) wr('h1000, 32'h1F00_0013);
    wait_idle();
    rd('h1000, v);
    chk(v == cw, poke ? "R7 control write during walk ignored" : "R2 control read-back", v, cw);
    chk(got_n == e_n, "R3 number of requests in walk", got_n, e_n);
    rd('h10, v);
    chk(v == 1, "R8 completion status set", v, 1);
    chk(irq == !mask_m, "R10 irq follows mask", irq, !mask_m);
    wr('h8, 1);
    rd('h10, v);
    chk(v == 0, "R9 status cleared", v, 0);
    chk(irq == 0, "R10 irq low after clear", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int unsigned v;
    int unsigned sizes[10] = '{1, 127, 128, 129, 255, 256, 300, 600, 0, 384};
    repeat (3) @(negedge clk);
    #1 chk(irq == 0 && mreq_valid == 0, "R12 outputs idle in reset", {irq, mreq_valid}, 0);
    rst_n = 1'b1;
    rd('h14, v); chk(v == 0, "R12 not busy after reset", v, 0);
    rd('h10, v); chk(v == 0, "R12 status clear after reset", v, 0);
    rd('hC, v);  chk(v == 0, "R12 mask clear after reset", v, 0);
    rd('h1010 + 17 * 24 + 16, v); chk(v == 0, "R12 descriptor control reset", v, 0);

    prog(31, 32'h0000_1234, 77, 32'h9000_0040, 3'b101);
    rd('h1010 + 31 * 24, v);      chk(v == 32'h1234, "R1 offset read-back", v, 32'h1234);
    rd('h1010 + 31 * 24 + 4, v);  chk(v == 77, "R1 size read-back", v, 77);
    rd('h1010 + 31 * 24 + 8, v);  chk(v == 32'h9000_0040, "R1 address read-back", v, 32'h9000_0040);
    rd('h1010 + 31 * 24 + 16, v); chk(v == 5, "R1 control read-back", v, 5);
    prog(30, 32'h0000_2000, 513, 32'h9100_0000, 3'b001);

    for (int i = 0; i < 10; i++)
      prog(i, 32'(i) * 32'h400 + 3, sizes[i], 32'h4000_0010 + 32'(i) * 32'h1_0000,
           (i == 6) ? 3'b100 : ((i == 3) ? 3'b101 : 3'b001));
    rd('h1010 + 3 * 24 + 16, v); chk(v == 5, "R1 control read-back entry 3", v, 5);

    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 2; d++)
        for (int rm = 0; rm < 2; rm++) begin
          ready_mode = rm[0];
          run(0, 9, b[0], d[0], 4'(b * 2 + d + 8), 0);
        end

    for (int f = 0; f < 10; f++)
      for (int l = f; l < 10; l++) begin
        ready_mode = ((f + l) % 3) != 0;
        run(f, l, 1'((f + l) % 2), 1'(l % 2), 4'(f), 0);
      end

    ready_mode = 1;
    run(7, 7, 0, 1, 4'd5, 1);
    ready_mode = 0;
    run(7, 9, 1, 0, 4'd6, 1);

    ready_mode = 0;
    run(30, 31, 0, 1, 4'd3, 0);
    run(31, 31, 1, 0, 4'd1, 0);
    run(28, 31, 0, 0, 4'd2, 0);

    mask_m = 1; wr('hC, 1);
    rd('hC, v); chk(v == 1, "R10 mask read-back", v, 1);
    run(1, 3, 0, 0, 4'd4, 0);
    build(2, 2, 0); got_n = 0; e_dir = 0; e_br = 0;
    wr('h1000, cword(2, 2, 0, 0, 0));
    wait_idle();
    chk(irq == 0, "R10 irq blocked while masked", irq, 0);
    mask_m = 0; wr('hC, 0);
    #1 chk(irq == 1, "R10 irq rises on unmask", irq, 1);
    wr('h8, 0);
    rd('h10, v); chk(v == 1, "R9 writing 0 to clear has no effect", v, 1);
    wr('h8, 1);
    #1 chk(irq == 0, "R9 clear drops irq", irq, 0);

    ready_mode = 1;
    build(0, 0, 0); got_n = 0; e_dir = 1; e_br = 4'd7;
    wr('h1000, cword(0, 0, 0, 1, 4'd7));
    wr('h8, 1);
    rd('h10, v); chk(v == 1, "R9 completion wins over same-edge clear", v, 1);
    wait_idle();
    chk(got_n == 1, "R3 single-burst walk", got_n, 1);
    wr('h8, 1);

    build(5, 2, 0); got_n = 0;
    wr('h1000, cword(5, 2, 0, 0, 0));
    rd('h14, v); chk(v == 0, "R11 reversed range never busy", v, 0);
    rd('h10, v); chk(v == 1, "R11 reversed range sets status", v, 1);
    chk(got_n == 0, "R11 reversed range issues nothing", got_n, 0);
    wr('h8, 1);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule